// File: doc/BRIEF.md
# DLL Reset Read Lockout Timer

This block sits in the command path of a DRAM controller. It watches writes to the primary mode register. A write whose delay-locked-loop reset bit is set starts a fixed lock-wait window. While that window runs, READ requests are refused and a lockout status stays high. A running wait is only valid while clock enable stays high. If clock enable drops, or a READ is attempted during the window, the block pulses a violation flag. A clock-enable drop also starts the wait again from zero.

The block keeps a shadow copy of the last value written. The reset-trigger bit (bit 8) in that copy clears itself one cycle after the write, because the trigger acts once and is never held. All other fields are kept as written, including the write-recovery setting in bits 11:9. A READ requested outside the window goes straight to the grant in the same cycle.

Top module: `dllrg_read_lockout`

## Requirements
- R1: A mode-register write (`mrw_valid_i` high at a clock edge) stores `mrw_value_i` into `mr_shadow_o`, visible from the next cycle. Every bit except bit 8 is stored unchanged, including the write-recovery field in bits 11:9.
- R2: Bit 8 of `mr_shadow_o` reads 1 for exactly one cycle after a write with bit 8 set. It then returns to 0.
- R3: A write with bit 8 set raises `lockout_o` from the cycle after the write. With `cke_i` held high, `lockout_o` stays high for exactly LOCK_CYCLES cycles (512 by default) and then falls.
- R4: While `lockout_o` is high, `rd_grant_o` is 0. While it is low, `rd_grant_o` equals `rd_req_i` in the same cycle, including the cycle of the triggering write.
- R5: A READ request in a cycle where `lockout_o` is high makes `viol_o` high in the next cycle only. Neither a READ request nor a low `cke_i` outside the lockout raises `viol_o`.
- R6: `cke_i` low in a lockout cycle makes `viol_o` high in the next cycle and restarts the wait. `lockout_o` then stays high for LOCK_CYCLES cycles after that cycle.
- R7: A new write with bit 8 set during a lockout restarts the wait. `lockout_o` then stays high for LOCK_CYCLES cycles after the new write.
- R8: A write with bit 8 clear starts no lockout and does not change the timing of a lockout already running. It does update the shadow copy.
- R9: While `rst_ni` is low, the outputs take these values at once: `lockout_o` = 0, `viol_o` = 0, `mr_shadow_o` = 0, and `rd_grant_o` follows `rd_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mrw_valid_i | input | 1 | Primary mode-register write strobe |
| mrw_value_i | input | 13 | Value written to the mode register |
| cke_i | input | 1 | Clock-enable level |
| rd_req_i | input | 1 | READ request |
| rd_grant_o | output | 1 | READ grant |
| lockout_o | output | 1 | High while the lock wait is running |
| mr_shadow_o | output | 13 | Stored register value with self-clearing bit 8 |
| viol_o | output | 1 | One-cycle violation pulse |

## Verification
The bench builds the block with LOCK_CYCLES set to 16 rather than 512. With this value, the full window, its end and the restarts are each measured to the exact cycle within a short run. The measurements cover a restart from a clock-enable drop, a restart from a repeated trigger write, and a non-trigger write partway through a window. In every case the bench checks the count from the restart point and the point where a READ is first granted again.

// File: rtl/dllrg_pkg.sv
package dllrg_pkg;

  // Defaults shared by the block and its checker.
  localparam int unsigned MR_W_DEF        = 13;
  localparam int unsigned TRIG_BIT_DEF    = 8;
  localparam int unsigned LOCK_CYCLES_DEF = 512;

  // Lock-wait sequencer state.
  typedef enum logic {
    LK_IDLE = 1'b0,
    LK_WAIT = 1'b1
  } lk_state_e;

endpackage

// File: rtl/dllrg_mr_shadow.sv
module dllrg_mr_shadow #(
  parameter int unsigned MR_W     = dllrg_pkg::MR_W_DEF,
  parameter int unsigned TRIG_BIT = dllrg_pkg::TRIG_BIT_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mrw_valid_i,
  input  logic [MR_W-1:0] mrw_value_i,
  output logic            trig_o,
  output logic [MR_W-1:0] shadow_o
);

  localparam logic [MR_W-1:0] TRIG_MASK = MR_W'(1) << TRIG_BIT;

  logic [MR_W-1:0] shadow_q, shadow_d;
  logic            shadow_en;

  assign trig_o = mrw_valid_i & mrw_value_i[TRIG_BIT];

  // A write loads the whole value. Otherwise the trigger bit is cleared
  // whenever it is set, so it never survives past one cycle.
  always_comb begin
    shadow_d  = shadow_q;
    shadow_en = 1'b0;
    if (mrw_valid_i) begin
      shadow_d  = mrw_value_i;
      shadow_en = 1'b1;
    end else if (shadow_q[TRIG_BIT]) begin
      shadow_d  = shadow_q & ~TRIG_MASK;
      shadow_en = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (shadow_en) begin
      shadow_q <= shadow_d;
    end
  end

  assign shadow_o = shadow_q;

endmodule

// File: rtl/dllrg_lock_timer.sv
module dllrg_lock_timer
  import dllrg_pkg::*;
#(
  parameter int unsigned LOCK_CYCLES = LOCK_CYCLES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic cke_i,
  output logic lock_o,
  output logic cke_fault_o
);

  localparam int unsigned CNT_W = $clog2(LOCK_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

  lk_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cke_fault_o = (state_q == LK_WAIT) & ~cke_i;

  // Next-state logic. A trigger always wins and restarts from zero.
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (trig_i) begin
      state_d = LK_WAIT;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (state_q == LK_WAIT) begin
      cnt_en = 1'b1;
      if (!cke_i) begin
        cnt_d = '0;
      end else if (cnt_q == CNT_LAST) begin
        state_d = LK_IDLE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LK_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign lock_o = (state_q == LK_WAIT);

endmodule

// File: rtl/dllrg_read_gate.sv
module dllrg_read_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  input  logic cke_fault_i,
  input  logic rd_req_i,
  output logic rd_grant_o,
  output logic viol_o
);

  logic viol_q, viol_d;

  assign rd_grant_o = rd_req_i & ~lock_i;

  // A refused read or a clock-enable drop in the wait flags one cycle later.
  always_comb begin
    viol_d = (lock_i & rd_req_i) | cke_fault_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q <= 1'b0;
    end else begin
      viol_q <= viol_d;
    end
  end

  assign viol_o = viol_q;

endmodule

// File: rtl/dllrg_read_lockout.sv
module dllrg_read_lockout
  import dllrg_pkg::*;
#(
  parameter int unsigned MR_W        = MR_W_DEF,
  parameter int unsigned TRIG_BIT    = TRIG_BIT_DEF,
  parameter int unsigned LOCK_CYCLES = LOCK_CYCLES_DEF
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mrw_valid_i,
  input  logic [MR_W-1:0] mrw_value_i,
  input  logic            cke_i,
  input  logic            rd_req_i,
  output logic            rd_grant_o,
  output logic            lockout_o,
  output logic [MR_W-1:0] mr_shadow_o,
  output logic            viol_o
);

  logic trig;
  logic lock;
  logic cke_fault;

  dllrg_mr_shadow #(
    .MR_W     (MR_W),
    .TRIG_BIT (TRIG_BIT)
  ) shadow_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mrw_valid_i (mrw_valid_i),
    .mrw_value_i (mrw_value_i),
    .trig_o      (trig),
    .shadow_o    (mr_shadow_o)
  );

  dllrg_lock_timer #(
    .LOCK_CYCLES (LOCK_CYCLES)
  ) timer_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig),
    .cke_i       (cke_i),
    .lock_o      (lock),
    .cke_fault_o (cke_fault)
  );

  dllrg_read_gate gate_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lock_i      (lock),
    .cke_fault_i (cke_fault),
    .rd_req_i    (rd_req_i),
    .rd_grant_o  (rd_grant_o),
    .viol_o      (viol_o)
  );

  assign lockout_o = lock;

endmodule

// File: rtl/dllrg_checker.sv
module dllrg_checker #(
  parameter int unsigned MR_W     = dllrg_pkg::MR_W_DEF,
  parameter int unsigned TRIG_BIT = dllrg_pkg::TRIG_BIT_DEF
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            mrw_valid_i,
  input logic [MR_W-1:0] mrw_value_i,
  input logic            cke_i,
  input logic            rd_req_i,
  input logic            rd_grant_o,
  input logic            lockout_o,
  input logic [MR_W-1:0] mr_shadow_o,
  input logic            viol_o
);

  logic trig_w;
  assign trig_w = mrw_valid_i & mrw_value_i[TRIG_BIT];

  // R1: a write lands in the shadow copy, apart from the self-clearing bit.
  p_write_stored_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrw_valid_i |=> (mr_shadow_o == $past(mrw_value_i)));

  // R2: the trigger bit never stays set without a fresh trigger write.
  p_trig_self_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig_w) |=> !mr_shadow_o[TRIG_BIT]);

  // R3: a trigger write opens the lockout on the next cycle.
  p_lock_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_w |=> lockout_o);

  // R4: a grant only ever answers a request made outside the lockout.
  p_grant_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_grant_o |-> (rd_req_i && !lockout_o));

  // R5: a refused read is flagged on the following cycle.
  p_read_flagged_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lockout_o && rd_req_i) |=> viol_o);

  // R5: nothing outside the lockout produces a flag.
  p_idle_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lockout_o) |=> !viol_o);

  // R6: a clock-enable drop keeps the lockout and raises the flag.
  p_cke_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lockout_o && !cke_i) |=> (lockout_o && viol_o));

endmodule

bind dllrg_read_lockout dllrg_checker #(
  .MR_W     (MR_W),
  .TRIG_BIT (TRIG_BIT)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mrw_valid_i (mrw_valid_i),
  .mrw_value_i (mrw_value_i),
  .cke_i       (cke_i),
  .rd_req_i    (rd_req_i),
  .rd_grant_o  (rd_grant_o),
  .lockout_o   (lockout_o),
  .mr_shadow_o (mr_shadow_o),
  .viol_o      (viol_o)
);

// File: tb/dllrg_read_lockout_tb_top.sv
`timescale 1ns/100ps
module dllrg_read_lockout_tb_top;

  localparam int unsigned LOCK = 16;
  localparam int unsigned NVEC = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        mrw_valid_i;
  logic [12:0] mrw_value_i;
  logic        cke_i;
  logic        rd_req_i;
  logic        rd_grant_o;
  logic        lockout_o;
  logic [12:0] mr_shadow_o;
  logic        viol_o;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  dllrg_read_lockout #(
    .MR_W        (13),
    .TRIG_BIT    (8),
    .LOCK_CYCLES (LOCK)
  ) dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mrw_valid_i (mrw_valid_i),
    .mrw_value_i (mrw_value_i),
    .cke_i       (cke_i),
    .rd_req_i    (rd_req_i),
    .rd_grant_o  (rd_grant_o),
    .lockout_o   (lockout_o),
    .mr_shadow_o (mr_shadow_o),
    .viol_o      (viol_o)
  );

  // Vector layout: [31] write, [30:18] value, [17] cke, [16] read,
  // then expected [15] grant, [14] lockout, [13] violation, [12:0] shadow.
  // Each row gives the outputs seen in the cycle in which its inputs apply.
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b0, 13'h000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 13'h000},  // R9 idle after reset
    {1'b0, 13'h000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 13'h000},  // R4 read passes
    {1'b0, 13'h000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 13'h000},  // R4 cke low while idle
    {1'b1, 13'hA25, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 13'h000},  // R5 no flag from idle
    {1'b0, 13'h000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 13'hA25},  // R1 R8 stored, no lock
    {1'b1, 13'hF25, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 13'hA25},  // R4 grant in trigger cycle
    {1'b0, 13'h000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 13'hF25},  // R2 R3 bit 8 seen once
    {1'b0, 13'h000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 13'hE25},  // R2 R4 cleared, refused
    {1'b0, 13'h000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 13'hE25},  // R5 flag
    {1'b0, 13'h000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 13'hE25},  // R5 one cycle only
    {1'b0, 13'h000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 13'hE25},  // R6 flag from cke
    {1'b0, 13'h000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 13'hE25}   // R6 still locked
  };

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 ns later, before the rising edge.
  task automatic step(input logic v, input logic [12:0] val,
                      input logic c, input logic r);
    @(negedge clk_i);
    mrw_valid_i = v;
    mrw_value_i = val;
    cke_i       = c;
    rd_req_i    = r;
    #1;
  endtask

  task automatic idle();
    step(1'b0, 13'h000, 1'b1, 1'b0);
  endtask

  // Counts lockout cycles from the next cycle on; also gives the flag there.
  task automatic measure(output int n, output logic first_viol);
    n = 0;
    idle();
    first_viol = viol_o;
    while (lockout_o && n < 200) begin
      n++;
      idle();
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    int   n;
    logic fv;
    rst_ni      = 1'b0;
    mrw_valid_i = 1'b0;
    mrw_value_i = '0;
    cke_i       = 1'b1;
    rd_req_i    = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][31], VEC[i][30:18], VEC[i][17], VEC[i][16]);
      check($sformatf("vec%0d grant R4", i),    int'(rd_grant_o),  int'(VEC[i][15]));
      check($sformatf("vec%0d lockout R3", i),  int'(lockout_o),   int'(VEC[i][14]));
      check($sformatf("vec%0d viol R5 R6", i),  int'(viol_o),      int'(VEC[i][13]));
      check($sformatf("vec%0d shadow R1", i),   int'(mr_shadow_o), int'(VEC[i][12:0]));
    end

    // R9: reset in the middle of a lockout.
    step(1'b0, 13'h000, 1'b1, 1'b1);
    rst_ni = 1'b0;
    #0.5;
    check("reset lockout R9", int'(lockout_o),   0);
    check("reset viol R9",    int'(viol_o),      0);
    check("reset shadow R9",  int'(mr_shadow_o), 0);
    check("reset grant R9",   int'(rd_grant_o),  1);
    @(negedge clk_i);
    rst_ni   = 1'b1;
    rd_req_i = 1'b0;

    // R3: full window with cke high, then the read is granted and not flagged.
    step(1'b1, 13'h100, 1'b1, 1'b0);
    measure(n, fv);
    check("window length R3", n, LOCK);
    step(1'b0, 13'h000, 1'b1, 1'b1);
    check("grant after window R4", int'(rd_grant_o), 1);
    idle();
    check("no flag after window R5", int'(viol_o), 0);

    // R7: repeated trigger restarts the window.
    do_reset();
    step(1'b1, 13'h100, 1'b1, 1'b0);
    repeat (6) idle();
    step(1'b1, 13'h100, 1'b1, 1'b0);
    check("locked before rewrite R7", int'(lockout_o), 1);
    measure(n, fv);
    check("restart by rewrite R7", n, LOCK);

    // R6: cke drop restarts the window and flags.
    do_reset();
    step(1'b1, 13'h100, 1'b1, 1'b0);
    repeat (5) idle();
    step(1'b0, 13'h000, 1'b0, 1'b0);
    measure(n, fv);
    check("cke drop flag R6", int'(fv), 1);
    check("restart by cke drop R6", n, LOCK);

    // R8: a non-trigger write mid-window leaves the timing alone.
    do_reset();
    step(1'b1, 13'h100, 1'b1, 1'b0);
    repeat (4) idle();
    step(1'b1, 13'h200, 1'b1, 1'b0);
    measure(n, fv);
    check("window kept after plain write R8", n, LOCK - 5);
    check("plain write stored R8", int'(mr_shadow_o), 'h200);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog R3: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

endmodule